// File: doc/BRIEF.md
# Parallel Sampling Converter Host Controller

This block sits in the programmable logic next to a 12-bit parallel-output sampling converter and runs each sample from start to finish. A request comes from a one-cycle trigger input or from an internal sample-rate tick with a programmable period. For each request the block drives the active-low conversion-start line low. It then follows the converter's busy line through its rise and fall, drops chip select and read together, and waits a programmable access time before it latches the data bus. The word is then offered on a valid/ready stream.

In the low-power option, conversion-start is kept low until busy has fallen, which lets the converter go to sleep after it has produced the result. The line is then raised to wake the converter. The block waits a wake-up time before it accepts the next request, and that time depends on whether the converter was set for light or deep sleep. A busy watchdog ends a conversion that never starts or never completes, reports it with a one-cycle error pulse, and puts the block back in its idle state.

Top module: `smp_host_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, conversion-start, chip select and read are high (inactive), and `s_valid_o` and `err_o` are low.
- R2: In normal mode (`pwr_save_i`=0), an accepted request drives `cnv_n_o` low for exactly CNV_LOW cycles. The line returns high before busy falls, so the converter does not sleep.
- R3: Chip select and read fall together only after busy has been seen high and then low. Both stay low for `acc_i`+1 cycles, and the bus is sampled on the clock edge that ends the last of those cycles, so a word that appears later than that is not captured.
- R4: The captured word is presented on `s_data_o` with `s_valid_o` high. Both stay unchanged until a cycle in which `s_ready_i` is high, and `s_valid_o` drops on the following cycle.
- R5: A trigger or tick that arrives while a conversion is in progress, or while a sample is still waiting on the stream, is dropped. No conversion is started and the pending word is not changed.
- R6: In power-save mode (`pwr_save_i`=1), `cnv_n_o` stays low from the start until the read has finished, and then rises. The next fall of `cnv_n_o` comes no sooner than WAKE_PART+1 cycles after that rise when `deep_i`=0, and no sooner than WAKE_FULL+1 cycles when `deep_i`=1. With a request held active, it comes exactly that many cycles after the rise.
- R7: If busy is not seen high within `tmo_i`+1 cycles of the start phase ending, or is not seen low within `tmo_i`+1 cycles of being seen high, `err_o` pulses for one cycle. No sample is produced, the strobes stay high, conversion-start is released, and the block becomes ready for a new request.
- R8: While `auto_en_i` is high, requests are generated every `rate_i`+1 cycles, so successive conversion starts are `rate_i`+1 cycles apart. While it is low, no tick-driven conversion occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Request one sample |
| auto_en_i | input | 1 | Enable periodic sampling |
| rate_i | input | CNT_W | Periodic sample interval minus one, in cycles |
| pwr_save_i | input | 1 | Hold conversion-start low through conversion (converter sleeps) |
| deep_i | input | 1 | Sleep depth chosen on the converter: 1 = deep, selects the longer wake wait |
| acc_i | input | ACC_W | Bus access wait after strobes fall, in cycles |
| tmo_i | input | CNT_W | Busy watchdog limit, in cycles |
| cnv_n_o | output | 1 | Conversion-start to converter, active low |
| cs_n_o | output | 1 | Chip select to converter, active low |
| rd_n_o | output | 1 | Read strobe to converter, active low |
| busy_i | input | 1 | Converter busy, asynchronous |
| data_i | input | DW | Converter data bus |
| s_valid_o | output | 1 | Sample available |
| s_data_o | output | DW | Sample word |
| s_ready_i | input | 1 | Consumer accepts sample |
| err_o | output | 1 | One-cycle busy timeout pulse |

## Verification
The bench builds the block with CNV_LOW=2, WAKE_PART=8 and WAKE_FULL=40, and runs it with a watchdog limit of 30 cycles. At these values both wake-up windows and both timeout paths complete within a few dozen cycles, so the bench can measure exact gaps from wake-up rise to the next start. Its converter model produces a wrong word until strobes have been low for three cycles, so an access setting of one is expected to capture that wrong word and a setting of two the right one. The periodic mode runs with an interval of 100 cycles, which is long enough for a full conversion between ticks.

// File: rtl/smp_pkg.sv
// Package: shared types for the sampling converter host controller.
// Assumes nothing beyond its users agreeing on the state encoding.
package smp_pkg;

    // Phases of one sample sequence.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_WAIT_HI = 3'd2,
        ST_WAIT_LO = 3'd3,
        ST_READ    = 3'd4,
        ST_WAKE    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/smp_sync.sv
// Module: smp_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops. Assumes the input changes slowly relative to clk, as a
// converter busy line does; STAGES picks the chain length (1 or more).
module smp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_multi
            // Shift the level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/smp_tick.sv
// Module: smp_tick
// Periodic request generator: while en_i is high it emits a one-cycle
// pulse every rate_i+1 cycles. Dropping en_i clears the count, so the
// first pulse after enabling comes rate_i+1 cycles later.
module smp_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] rate_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt;

    // Count up to rate_i, pulse, and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == rate_i) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/smp_seq.sv
// Module: smp_seq
// Sequencer for one conversion: start pulse, busy rise/fall tracking
// with watchdog, strobed read with access wait, output stream register,
// and the wake-up wait after a power-save conversion.
// Assumes busy_i is already synchronous. Mode and access settings are
// latched when a sequence starts and hold for that whole sequence.
module smp_seq
    import smp_pkg::*;
#(
    parameter int DW        = 12,
    parameter int CNT_W     = 16,
    parameter int ACC_W     = 4,
    parameter int CNV_LOW   = 2,
    parameter int WAKE_PART = 50,
    parameter int WAKE_FULL = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             pwr_save_i,
    input  logic             deep_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [CNT_W-1:0] tmo_i,
    input  logic             busy_i,
    input  logic [DW-1:0]    data_i,
    input  logic             s_ready_i,
    output logic             cnv_n_o,
    output logic             strb_n_o,
    output logic             s_valid_o,
    output logic [DW-1:0]    s_data_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(CNV_LOW - 1);
    localparam logic [CNT_W-1:0] WP_LAST    = CNT_W'(WAKE_PART - 1);
    localparam logic [CNT_W-1:0] WF_LAST    = CNT_W'(WAKE_FULL - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             pwr_q;
    logic             deep_q;
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] wake_last;
    logic [CNT_W-1:0] acc_last;

    // Wake wait length and access wait limit for the latched settings.
    always_comb begin
        wake_last = deep_q ? WF_LAST : WP_LAST;
        acc_last  = CNT_W'(acc_q);
    end

    // Main sequencer: one state register, one shared phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cnv_n_o   <= 1'b1;
            strb_n_o  <= 1'b1;
            s_valid_o <= 1'b0;
            s_data_o  <= '0;
            err_o     <= 1'b0;
            pwr_q     <= 1'b0;
            deep_q    <= 1'b0;
            acc_q     <= '0;
        end else begin
            err_o <= 1'b0;
            if (s_valid_o && s_ready_i) s_valid_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_i && !s_valid_o) begin
                        cnv_n_o <= 1'b0;
                        cnt     <= '0;
                        pwr_q   <= pwr_save_i;
                        deep_q  <= deep_i;
                        acc_q   <= acc_i;
                        state   <= ST_START;
                    end
                end
                ST_START: begin
                    if (cnt == START_LAST) begin
                        if (!pwr_q) cnv_n_o <= 1'b1;
                        cnt   <= '0;
                        state <= ST_WAIT_HI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (busy_i) begin
                        cnt   <= '0;
                        state <= ST_WAIT_LO;
                    end else if (cnt == tmo_i) begin
                        err_o   <= 1'b1;
                        cnv_n_o <= 1'b1;
                        cnt     <= '0;
                        state   <= pwr_q ? ST_WAKE : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT_LO: begin
                    if (!busy_i) begin
                        strb_n_o <= 1'b0;
                        cnt      <= '0;
                        state    <= ST_READ;
                    end else if (cnt == tmo_i) begin
                        err_o   <= 1'b1;
                        cnv_n_o <= 1'b1;
                        cnt     <= '0;
                        state   <= pwr_q ? ST_WAKE : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt == acc_last) begin
                        s_data_o  <= data_i;
                        s_valid_o <= 1'b1;
                        strb_n_o  <= 1'b1;
                        cnt       <= '0;
                        if (pwr_q) begin
                            cnv_n_o <= 1'b1;
                            state   <= ST_WAKE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (cnt == wake_last) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnv_n_o  <= 1'b1;
                    strb_n_o <= 1'b1;
                    cnt      <= '0;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/smp_host_ctrl.sv
// Module: smp_host_ctrl (top)
// Host-side controller for a parallel sampling converter. It merges
// trigger and periodic requests, synchronizes the converter's busy line
// and runs the conversion/read sequence. Chip select and read are driven
// as one strobe. Assumes data_i is stable once the access wait has passed.
module smp_host_ctrl #(
    parameter int DW          = 12,
    parameter int CNT_W       = 16,
    parameter int ACC_W       = 4,
    parameter int CNV_LOW     = 2,
    parameter int WAKE_PART   = 50,
    parameter int WAKE_FULL   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             auto_en_i,
    input  logic [CNT_W-1:0] rate_i,
    input  logic             pwr_save_i,
    input  logic             deep_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [CNT_W-1:0] tmo_i,
    output logic             cnv_n_o,
    output logic             cs_n_o,
    output logic             rd_n_o,
    input  logic             busy_i,
    input  logic [DW-1:0]    data_i,
    output logic             s_valid_o,
    output logic [DW-1:0]    s_data_o,
    input  logic             s_ready_i,
    output logic             err_o
);

    logic busy_q;
    logic tick;
    logic req;
    logic strb_n;

    smp_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (busy_i),
        .q_o   (busy_q)
    );

    smp_tick #(.CNT_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (auto_en_i),
        .rate_i (rate_i),
        .tick_o (tick)
    );

    // Either source may request a sample.
    always_comb req = trig_i | tick;

    smp_seq #(
        .DW        (DW),
        .CNT_W     (CNT_W),
        .ACC_W     (ACC_W),
        .CNV_LOW   (CNV_LOW),
        .WAKE_PART (WAKE_PART),
        .WAKE_FULL (WAKE_FULL)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .pwr_save_i (pwr_save_i),
        .deep_i     (deep_i),
        .acc_i      (acc_i),
        .tmo_i      (tmo_i),
        .busy_i     (busy_q),
        .data_i     (data_i),
        .s_ready_i  (s_ready_i),
        .cnv_n_o    (cnv_n_o),
        .strb_n_o   (strb_n),
        .s_valid_o  (s_valid_o),
        .s_data_o   (s_data_o),
        .err_o      (err_o)
    );

    // Both strobes move together.
    always_comb begin
        cs_n_o = strb_n;
        rd_n_o = strb_n;
    end

endmodule

// File: rtl/smp_host_ctrl_chk.sv
// Module: smp_host_ctrl_chk
// Protocol checker bound into smp_host_ctrl. It watches the converter-side
// strobes, the synchronized busy level and the output stream.
module smp_host_ctrl_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnv_n_o,
    input logic          cs_n_o,
    input logic          rd_n_o,
    input logic          busy_q,
    input logic          s_valid_o,
    input logic [DW-1:0] s_data_o,
    input logic          s_ready_i,
    input logic          err_o
);

    // R1: outputs idle on the cycle after a reset cycle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cnv_n_o && cs_n_o && rd_n_o && !s_valid_o && !err_o));

    // R3: chip select and read always move together.
    a_r3_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o == rd_n_o);

    // R3: strobes only fall once busy is seen low.
    a_r3_read_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !busy_q);

    // R4: a pending sample stays put until accepted.
    a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_o && !s_ready_i) |=> (s_valid_o && $stable(s_data_o)));

    // R5: no conversion start while a sample is pending.
    a_r5_no_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_o && cnv_n_o) |=> cnv_n_o);

    // R7: the error is a single-cycle pulse.
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R7: an error never comes with a sample.
    a_r7_err_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!s_valid_o && cs_n_o));

endmodule

bind smp_host_ctrl smp_host_ctrl_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_n_o   (cnv_n_o),
    .cs_n_o    (cs_n_o),
    .rd_n_o    (rd_n_o),
    .busy_q    (busy_q),
    .s_valid_o (s_valid_o),
    .s_data_o  (s_data_o),
    .s_ready_i (s_ready_i),
    .err_o     (err_o)
);

// File: tb/tb_smp_host_ctrl.sv
`timescale 1ns/1ps
// Bench for smp_host_ctrl: vector table walked by one loop, then directed
// tests. A behavioural converter model runs on the falling clock edge.
module tb_smp_host_ctrl;

    localparam int DW = 12, CW = 16, AW = 4;
    localparam int CNV_LOW = 2, WP = 8, WF = 40;
    localparam int BUSY_DLY = 3, CONV = 20, ACC_NEED = 2;
    localparam logic [11:0] BAD = 12'hBAD;

    // {pwr_save, deep, acc[3:0], word[11:0]}
    localparam logic [17:0] VEC [4] = '{
        {1'b0, 1'b0, 4'd2, 12'hA5C},
        {1'b0, 1'b0, 4'd5, 12'h001},
        {1'b1, 1'b0, 4'd3, 12'hFFF},
        {1'b1, 1'b1, 4'd2, 12'h7E1}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, trig, auto_en, pwr, deep, ready;
    logic [CW-1:0] rate, tmo;
    logic [AW-1:0] acc;
    logic cnv_n, cs_n, rd_n, s_valid, err;
    logic [DW-1:0] s_data;
    logic busy_m;
    logic [DW-1:0] data_m;

    smp_host_ctrl #(
        .DW(DW), .CNT_W(CW), .ACC_W(AW), .CNV_LOW(CNV_LOW),
        .WAKE_PART(WP), .WAKE_FULL(WF), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .auto_en_i(auto_en),
        .rate_i(rate), .pwr_save_i(pwr), .deep_i(deep), .acc_i(acc),
        .tmo_i(tmo), .cnv_n_o(cnv_n), .cs_n_o(cs_n), .rd_n_o(rd_n),
        .busy_i(busy_m), .data_i(data_m), .s_valid_o(s_valid),
        .s_data_o(s_data), .s_ready_i(ready), .err_o(err)
    );

    int tests = 0, fails = 0;
    int cyc = 0, ph = 0;
    bit prev_cnv = 1'b1, asleep = 0, woke = 0, slept = 0;
    bit norise = 0, stuck = 0, mclr = 0;
    int wake_t = 0, gap = 0, n_starts = 0, low_w = 0;
    int last_start = 0, prev_start = 0, rd_busy = 0, lo_cnt = 0;
    logic [DW-1:0] word_m = '0;

    // Converter model: busy after a start, sleep/wake tracking, slow bus.
    always @(negedge clk) begin
        cyc++;
        if (mclr) begin ph = 0; busy_m = 1'b0; mclr = 0; end
        if (ph > 0) begin
            ph++;
            if (ph == BUSY_DLY) busy_m = 1'b1;
            if (ph >= BUSY_DLY + CONV && !stuck) begin
                busy_m = 1'b0;
                ph = 0;
                if (cnv_n === 1'b0) begin asleep = 1; slept = 1; end
            end
        end
        if (prev_cnv && cnv_n === 1'b0) begin
            n_starts++;
            low_w = 1;
            prev_start = last_start;
            last_start = cyc;
            if (woke) begin gap = cyc - wake_t; woke = 0; end
            if (!norise) ph = 1;
        end else if (cnv_n === 1'b0) begin
            low_w++;
        end
        if (!prev_cnv && cnv_n === 1'b1 && asleep) begin
            asleep = 0; woke = 1; wake_t = cyc;
        end
        prev_cnv = (cnv_n !== 1'b0);
        if (cs_n === 1'b0 && rd_n === 1'b0) begin
            lo_cnt++;
            if (busy_m) rd_busy++;
            data_m = (lo_cnt > ACC_NEED) ? word_m : BAD;
        end else begin
            lo_cnt = 0;
            data_m = '0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (s_valid) begin got = 1; break; end
        end
    endtask

    task automatic wait_starts(input int target, output bit got);
        got = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (n_starts >= target) begin got = 1; break; end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit got;
        int n0, errs, vals;
        logic [DW-1:0] held;
        rst_n = 0; trig = 0; auto_en = 0; pwr = 0; deep = 0; ready = 0;
        rate = '0; tmo = 16'd30; acc = 4'd2; busy_m = 0; data_m = '0;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(cnv_n && cs_n && rd_n, "R1 strobes idle in reset", {cnv_n, cs_n, rd_n}, 3'b111);
        chk(!s_valid && !err, "R1 valid/err low in reset", {s_valid, err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cnv_n && cs_n && !s_valid, "R1 idle after reset", {cnv_n, cs_n, s_valid}, 3'b110);

        // Vector table: R2, R3, R4, R6
        for (int v = 0; v < 4; v++) begin
            pwr = VEC[v][17]; deep = VEC[v][16]; acc = VEC[v][15:12];
            word_m = VEC[v][11:0];
            slept = 0; rd_busy = 0; ready = 0;
            pulse_trig();
            wait_valid(got);
            chk(got, "R3 sample produced", got, 1);
            chk(s_data == VEC[v][11:0], "R3 captured word", s_data, VEC[v][11:0]);
            chk(slept == VEC[v][17], "R2/R6 sleep matches mode", slept, VEC[v][17]);
            chk(rd_busy == 0, "R3 no read while busy", rd_busy, 0);
            if (!VEC[v][17]) chk(low_w == CNV_LOW, "R2 start pulse width", low_w, CNV_LOW);
            held = s_data;
            repeat (5) @(negedge clk);
            chk(s_valid && s_data == held, "R4 held without ready", s_data, held);
            ready = 1;
            @(negedge clk);
            @(negedge clk);
            chk(!s_valid, "R4 valid drops after ready", s_valid, 0);
            ready = 0;
            repeat (60) @(negedge clk);
        end

        // R3: access wait too short captures the slow bus early
        pwr = 0; acc = 4'd1; word_m = 12'h123;
        pulse_trig();
        wait_valid(got);
        chk(s_data == BAD, "R3 sampled after acc+1 cycles", s_data, BAD);
        ready = 1; repeat (3) @(negedge clk); ready = 0;
        acc = 4'd2;

        // R5: requests refused during conversion and while pending
        word_m = 12'h3C3; n0 = n_starts;
        pulse_trig();
        repeat (8) @(negedge clk);
        pulse_trig();
        wait_valid(got);
        pulse_trig(); pulse_trig();
        repeat (20) @(negedge clk);
        chk(n_starts - n0 == 1, "R5 extra triggers refused", n_starts - n0, 1);
        chk(s_valid && s_data == 12'h3C3, "R5 pending word kept", s_data, 12'h3C3);
        ready = 1; repeat (3) @(negedge clk);

        // R6: wake gap, light then deep, request held
        pwr = 1; deep = 0; trig = 1; n0 = n_starts;
        wait_starts(n0 + 3, got);
        trig = 0;
        chk(got && gap == WP + 1, "R6 light wake gap", gap, WP + 1);
        repeat (100) @(negedge clk);
        deep = 1; trig = 1; n0 = n_starts;
        wait_starts(n0 + 3, got);
        trig = 0;
        chk(got && gap == WF + 1, "R6 deep wake gap", gap, WF + 1);
        repeat (100) @(negedge clk);
        pwr = 0; deep = 0;

        // R7: busy never rises
        norise = 1; errs = 0; vals = 0;
        pulse_trig();
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (err) errs++;
            if (s_valid) vals++;
        end
        chk(errs == 1 && vals == 0, "R7 no-rise timeout", errs, 1);
        chk(cnv_n && cs_n, "R7 lines released", {cnv_n, cs_n}, 2'b11);
        norise = 0;

        // R7: busy never falls
        stuck = 1; errs = 0; vals = 0;
        pulse_trig();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (err) errs++;
            if (s_valid) vals++;
        end
        chk(errs == 1 && vals == 0, "R7 no-fall timeout", errs, 1);
        stuck = 0; mclr = 1;
        repeat (10) @(negedge clk);
        word_m = 12'h5A5;
        pulse_trig();
        wait_valid(got);
        chk(got && s_data == 12'h5A5, "R7 recovers after error", s_data, 12'h5A5);
        repeat (3) @(negedge clk);

        // R8: periodic requests
        rate = 16'd99; auto_en = 1; n0 = n_starts;
        wait_starts(n0 + 3, got);
        chk(got && (last_start - prev_start) == 100, "R8 tick interval", last_start - prev_start, 100);
        auto_en = 0;
        repeat (150) @(negedge clk);
        n0 = n_starts;
        repeat (300) @(negedge clk);
        chk(n_starts == n0, "R8 no ticks when disabled", n_starts, n0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule